// File: doc/BRIEF.md
# Bus Request Priority Generator

This block drives the urgency flag that travels with a data cache's request to the system bus. Each cycle it looks at the kind of operation that currently holds the bus request and at the command waiting behind it. From that pair it decides whether the pipeline is stalled on the cache and needs the bus quickly. A fixed rule table makes the decision, not the age of the request and not a set of levels. The flag is registered, so it is glitch-free and follows the inputs sampled at the previous rising edge.

The decision is kept as a three-state machine:
- `ST_IDLE`: no bus request.
- `ST_CALM`: a request with low urgency.
- `ST_URGENT`: a request with high urgency.

On every clock edge the machine may move from any state to any state. It takes the *release* transition to `ST_IDLE` when no request is active. It takes the *escalate* transition to `ST_URGENT` when the rule table asks for urgency. It takes the *settle* transition to `ST_CALM` otherwise. The output is high only in `ST_URGENT`.

Operation codes on `req_op` are:

| Code | Operation |
|---|---|
| 0 | load from external memory |
| 1 | store |
| 2 | line flush |
| 3 | line write-back |
| 4 | touch |
| 5 | line invalidate |
| 6 | whole-cache invalidate |
| 7 | line zero |

Every `nxt_*` qualifier is ignored unless `nxt_valid` is high.

Top module: `bus_prio_gen`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset is released with no request, `prio` is 0.
- R2: If `req_active` is 0 at a rising edge, `prio` is 0 after that edge, whatever the other inputs are. This includes the cycle right after a request ends.
- R3: With a request of code 0 (external load), `prio` is 1 after the edge, whatever the next-command inputs are.
- R4: With a request of code 1 (store), `prio` is 1 after the edge exactly when `nxt_valid`=1 and `nxt_accept`=0. Otherwise it is 0.
- R5: With a request of code 2 or 3, `prio` is 0 after the edge when `nxt_valid`=1 and `nxt_hit`=1. The hit wins over the other next-command flags.
- R6: With a request of code 2 or 3, `prio` is 1 after the edge when `nxt_valid`=1, `nxt_hit`=0 and `nxt_ncload`=1.
- R7: With a request of code 2 or 3, `prio` is 1 after the edge when `nxt_valid`=1, `nxt_hit`=0 and `nxt_flush`=1.
- R8: With a request of code 2 or 3, `prio` is 0 after the edge when no next command is valid, or when the valid one misses with both `nxt_ncload` and `nxt_flush` at 0.
- R9: With a request of code 4 (touch), `prio` is 0 after the edge, whatever the next-command inputs are.
- R10: With a request of code 5, 6 or 7 (invalidate line, invalidate all, zero line), `prio` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_active | input | 1 | The cache is requesting the bus |
| req_op | input | 3 | Code of the operation holding the request |
| nxt_valid | input | 1 | A next command is presented to the cache |
| nxt_hit | input | 1 | The next command hits in the cache |
| nxt_accept | input | 1 | The cache accepts the next command this cycle |
| nxt_ncload | input | 1 | The next command is a non-cacheable load |
| nxt_flush | input | 1 | The next command needs a line flush of its own |
| prio | output | 1 | Registered urgency flag for the bus request |

## Verification
The properties assume that `req_op` holds a defined code whenever `req_active` is high, and that the next-command flags have defined values at every edge. The flags may be mutually inconsistent (for example, hit together with a non-cacheable load); the hit-first precedence in R5 settles those cases. The directed stimulus changes inputs only on falling edges, so every rising edge samples stable values. It deliberately raises contradictory flag combinations to exercise that precedence. Every check compares `prio` one edge after the stimulus.

// File: rtl/bus_prio_pkg.sv
package bus_prio_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD_EXT = 3'd0,
        OP_STORE    = 3'd1,
        OP_FLUSH    = 3'd2,
        OP_WBACK    = 3'd3,
        OP_TOUCH    = 3'd4,
        OP_INV_LINE = 3'd5,
        OP_INV_ALL  = 3'd6,
        OP_ZERO     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALM   = 2'd1,
        ST_URGENT = 2'd2
    } state_e;

    typedef struct packed {
        logic valid;
        logic hit;
        logic accept;
        logic ncload;
        logic flush;
    } nxt_t;

endpackage

// File: rtl/bus_prio_rule.sv
module bus_prio_rule
    import bus_prio_pkg::*;
(
    input  op_e  op,
    input  nxt_t nxt,
    output logic urgent
);
    logic flush_family_urgent;

    // Line-flush and write-back share one rule: a hit keeps it calm,
    // a miss that needs the bus itself makes it urgent.
    always_comb begin
        flush_family_urgent = 1'b0;
        if (nxt.valid && !nxt.hit) begin
            flush_family_urgent = nxt.ncload | nxt.flush;
        end
    end

    always_comb begin
        urgent = 1'b0;
        unique case (op)
            OP_LOAD_EXT: urgent = 1'b1;
            OP_STORE:    urgent = nxt.valid & ~nxt.accept;
            OP_FLUSH,
            OP_WBACK:    urgent = flush_family_urgent;
            OP_TOUCH:    urgent = 1'b0;
            OP_INV_LINE,
            OP_INV_ALL,
            OP_ZERO:     urgent = 1'b0;
            default:     urgent = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_prio_fsm.sv
module bus_prio_fsm
    import bus_prio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic urgent,
    output logic prio
);
    state_e state_q;
    state_e state_d;

    // Transition selection: release, escalate, settle.
    always_comb begin
        if (!active) begin
            state_d = ST_IDLE;
        end else if (urgent) begin
            state_d = ST_URGENT;
        end else begin
            state_d = ST_CALM;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode of the registered state.
    always_comb begin
        prio = 1'b0;
        unique case (state_q)
            ST_IDLE:   prio = 1'b0;
            ST_CALM:   prio = 1'b0;
            ST_URGENT: prio = 1'b1;
            default:   prio = 1'b0;
        endcase
    end
endmodule

// File: rtl/bus_prio_gen.sv
module bus_prio_gen
    import bus_prio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_active,
    input  logic [OP_W-1:0] req_op,
    input  logic            nxt_valid,
    input  logic            nxt_hit,
    input  logic            nxt_accept,
    input  logic            nxt_ncload,
    input  logic            nxt_flush,
    output logic            prio
);
    nxt_t nxt_s;
    logic urgent_s;

    assign nxt_s = '{valid:  nxt_valid,
                     hit:    nxt_hit,
                     accept: nxt_accept,
                     ncload: nxt_ncload,
                     flush:  nxt_flush};

    bus_prio_rule rule_i (
        .op     (op_e'(req_op)),
        .nxt    (nxt_s),
        .urgent (urgent_s)
    );

    bus_prio_fsm fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (req_active),
        .urgent (urgent_s),
        .prio   (prio)
    );
endmodule

// File: rtl/bus_prio_chk.sv
module bus_prio_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_active,
    input logic [2:0] req_op,
    input logic       nxt_valid,
    input logic       nxt_hit,
    input logic       nxt_accept,
    input logic       nxt_ncload,
    input logic       nxt_flush,
    input logic       prio
);
    logic fam;
    assign fam = req_active && (req_op == 3'd2 || req_op == 3'd3);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_low_chk: assert (!prio);
        end
    end

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_active |=> !prio);

    // R3
    load_ext_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_active && req_op == 3'd0) |=> prio);

    // R4
    store_stall_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_active && req_op == 3'd1 && nxt_valid && !nxt_accept) |=> prio);

    // R4
    store_flow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_active && req_op == 3'd1 && (!nxt_valid || nxt_accept)) |=> !prio);

    // R5
    flush_hit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fam && nxt_valid && nxt_hit) |=> !prio);

    // R6
    flush_ncload_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fam && nxt_valid && !nxt_hit && nxt_ncload) |=> prio);

    // R7
    flush_chain_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fam && nxt_valid && !nxt_hit && nxt_flush) |=> prio);

    // R8
    flush_plain_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fam && (!nxt_valid || (!nxt_hit && !nxt_ncload && !nxt_flush))) |=> !prio);

    // R9
    touch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_active && req_op == 3'd4) |=> !prio);

    // R10
    maint_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_active && req_op >= 3'd5) |=> !prio);
endmodule

bind bus_prio_gen bus_prio_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_active (req_active),
    .req_op     (req_op),
    .nxt_valid  (nxt_valid),
    .nxt_hit    (nxt_hit),
    .nxt_accept (nxt_accept),
    .nxt_ncload (nxt_ncload),
    .nxt_flush  (nxt_flush),
    .prio       (prio)
);

// File: tb/bus_prio_gen_tb_top.sv
module bus_prio_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_active = 1'b0;
    logic [2:0] req_op = 3'd0;
    logic       nxt_valid = 1'b0;
    logic       nxt_hit = 1'b0;
    logic       nxt_accept = 1'b0;
    logic       nxt_ncload = 1'b0;
    logic       nxt_flush = 1'b0;
    logic       prio;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_prio_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_active (req_active),
        .req_op     (req_op),
        .nxt_valid  (nxt_valid),
        .nxt_hit    (nxt_hit),
        .nxt_accept (nxt_accept),
        .nxt_ncload (nxt_ncload),
        .nxt_flush  (nxt_flush),
        .prio       (prio)
    );

    task automatic check(input logic exp, input string req, input string what);
        n_checks++;
        if (prio !== exp) begin
            n_fail++;
            $display("FAIL %s %s: prio=%b expected=%b", req, what, prio, exp);
        end
    endtask

    // Drive on a falling edge, let one rising edge register, and return
    // on the next falling edge.
    task automatic step(input logic a, input logic [2:0] op, input logic v,
                        input logic h, input logic acc, input logic nc,
                        input logic fl);
        @(negedge clk);
        req_active = a; req_op = op; nxt_valid = v; nxt_hit = h;
        nxt_accept = acc; nxt_ncload = nc; nxt_flush = fl;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(1'b0, "R1", "during reset");
        req_active = 1'b1; req_op = 3'd0;
        @(negedge clk);
        check(1'b0, "R1", "request held in reset");
        req_active = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, "R1", "after release");
    endtask

    task automatic t_idle();
        step(1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check(1'b0, "R2", "no request, load code");
        step(1'b0, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(1'b0, "R2", "no request, store stall flags");
    endtask

    task automatic t_load();
        step(1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(1'b1, "R3", "load, nothing next");
        step(1'b1, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check(1'b1, "R3", "load, next hits");
        step(1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(1'b0, "R2", "release after load");
    endtask

    task automatic t_store();
        step(1'b1, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check(1'b1, "R4", "store, next refused");
        step(1'b1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check(1'b0, "R4", "store, next accepted");
        step(1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check(1'b0, "R4", "store, no next");
    endtask

    task automatic t_flush_family();
        for (int k = 2; k <= 3; k++) begin
            step(1'b1, 3'(k), 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
            check(1'b0, "R5", "hit overrides flags");
            step(1'b1, 3'(k), 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
            check(1'b1, "R6", "next nc load");
            step(1'b1, 3'(k), 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
            check(1'b1, "R7", "next needs flush");
            step(1'b1, 3'(k), 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            check(1'b0, "R8", "plain miss");
            step(1'b1, 3'(k), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
            check(1'b0, "R8", "flags without valid");
        end
    endtask

    task automatic t_touch();
        step(1'b1, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check(1'b0, "R9", "touch, next hits");
        step(1'b1, 3'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        check(1'b0, "R9", "touch, stalled next");
    endtask

    task automatic t_maint();
        for (int k = 5; k <= 7; k++) begin
            step(1'b1, 3'(k), 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
            check(1'b0, "R10", "maintenance op");
        end
    endtask

    initial begin
        t_reset();
        t_idle();
        t_load();
        t_store();
        t_load();
        t_flush_family();
        t_load();
        t_touch();
        t_load();
        t_maint();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: expired=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule